// File: doc/BRIEF.md
# Timer Channel Control Register with Center-Aligned PWM

This block is one channel of a general-purpose timer. It holds the channel's byte-wide control and status register and the output logic that shapes a center-aligned pulse from an externally supplied up/down counter. Software reaches the register through a simple single-cycle read/write bus. A raw event strobe from the channel hardware sets a sticky event flag. The flag raises an interrupt request when the channel's interrupt enable is on.

The flag can only be cleared by a two-step handshake. Software first reads the register while the flag is set, which arms the clear. It then writes the register with bit 7 at zero. Any event that lands after the arming read, including one in the same cycle as the clearing write, cancels the clear. An event that software has not yet seen is therefore never discarded.

When the global center-aligned mode input is high, the channel output reacts to compare matches. A match while counting up moves the output to one level, and a match while counting down moves it to the opposite level. This produces a pulse centred on the counter's turnaround point. The edge/level field sets the polarity.

Top module: `tmr_chan_ctl`

## Requirements
- R1: The register answers only at bus address BASE_OFS + 3*CHAN_IDX (default 0x05 for channel 0, 0x08 for channel 1). Reads at any other address return 0x00, and writes there change nothing.
- R2: A read returns {flag, irq_enable, mode[1:0], edge_level[1:0], 2'b00}, with the flag in bit 7, the interrupt enable in bit 6, the mode bits in 5:4 and the edge/level bits in 3:2. Bits 1:0 always read 0, and a write sets bits 6:2 from the write data.
- R3: After reset, the register reads 0x00 and both the output pin and the interrupt request are 0.
- R4: A high event strobe sets the flag in the next cycle.
- R5: The flag clears only on a write with bit 7 = 0 that follows a read made while the flag was 1. A write without that read, a write with bit 7 = 1, or a write after a read that saw the flag at 0 leaves the flag set.
- R6: An event that arrives after the arming read, up to and including the cycle of the clearing write, leaves the flag set.
- R7: The interrupt request is 1 exactly when both the flag and the interrupt enable are 1.
- R8: While the center-aligned mode input is 0, the output pin holds its value.
- R9: In center-aligned mode with edge/level = 2'b10, a compare match (counter equals compare value) drives the output to 0 when counting up and to 1 when counting down, in the following cycle.
- R10: In center-aligned mode with edge/level = 2'b01 or 2'b11, a compare match drives the output to 1 when counting up and to 0 when counting down, in the following cycle.
- R11: With edge/level = 2'b00, the output holds its value.
- R12: Any write to the register cancels a pending arming, so a later write with bit 7 = 0 does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, valid while bus_rd is high |
| cnt_val | input | CNT_W | Timer counter value |
| cnt_up | input | 1 | 1 while the counter counts up, 0 while it counts down |
| cmp_val | input | CNT_W | Channel compare value |
| chan_evt | input | 1 | Raw channel event strobe |
| center_mode | input | 1 | Global center-aligned PWM enable |
| pwm_out | output | 1 | Channel output pin |
| irq | output | 1 | Channel interrupt request |

## Verification
The embedded assertions check four things on every cycle: that an event always leaves the flag set, that the flag never drops without an armed read, that an event racing an armed clear keeps the flag, and that the output responds correctly to matches or holds when the mode or the edge/level field forbids a change. Three properties need arranged access sequences and can only be shown by the bench scenarios. These are the actual success of a full read-then-write clear, the cancellation of arming by an intervening write, and the invisibility of the register at other addresses. The bench also sweeps every edge/level setting against every compare value over full up/down counter triangles to establish the exact output waveform.

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl #(
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int CHAN_IDX = 0,
  parameter int BASE_OFS = 5,
  parameter int STRIDE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_up,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              chan_evt,
  input  logic              center_mode,
  output logic              pwm_out,
  output logic              irq
);

  localparam int MY_ADDR = BASE_OFS + STRIDE * CHAN_IDX;

  logic       flag, armed, ie;
  logic [1:0] msel, els;

  wire hit     = (bus_addr == ADDR_W'(MY_ADDR));
  wire rd_hit  = hit && bus_rd;
  wire wr_hit  = hit && bus_wr;
  wire do_clr  = wr_hit && !bus_wdata[7] && armed;
  wire match   = (cnt_val == cmp_val);
  wire active  = (els != 2'b00);
  wire fire    = center_mode && match && active;

  assign bus_rdata = rd_hit ? {flag, ie, msel, els, 2'b00} : 8'h00;
  assign irq       = flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      msel <= 2'b00;
      els  <= 2'b00;
    end else if (wr_hit) begin
      ie   <= bus_wdata[6];
      msel <= bus_wdata[5:4];
      els  <= bus_wdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (chan_evt) flag <= 1'b1;
    else if (do_clr)  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (wr_hit || chan_evt) armed <= 1'b0;
    else if (rd_hit && flag)     armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pwm_out <= 1'b0;
    else if (fire) pwm_out <= cnt_up ? els[0] : ~els[0];
  end

  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    chan_evt |=> flag);

  a_r5_no_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);

  a_r6_race_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && chan_evt && wr_hit) |=> flag);

  a_r8_hold_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !center_mode |=> $stable(pwm_out));

  a_r9_up_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && match && cnt_up && els == 2'b10) |=> !pwm_out);

  a_r10_up_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && match && cnt_up && els[0]) |=> pwm_out);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (els == 2'b00 && !wr_hit) |=> $stable(pwm_out));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (bus_rdata[7] || !rd_hit));

endmodule

// File: tb/tb_tmr_chan_ctl.sv
module tb_tmr_chan_ctl;
  localparam int CLK_P = 10;
  localparam int CW = 4;
  localparam logic [7:0] ADR = 8'h08;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rd = 0, bus_wr = 0;
  logic [CW-1:0] cnt_val = 0, cmp_val = 0;
  logic cnt_up = 1, chan_evt = 0, center_mode = 0;
  logic pwm_out, irq;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  always #(CLK_P/2) clk = ~clk;

  tmr_chan_ctl #(.CNT_W(CW), .ADDR_W(8), .CHAN_IDX(1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .cmp_val(cmp_val), .chan_evt(chan_evt), .center_mode(center_mode),
    .pwm_out(pwm_out), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic ev = 0);
    bus_addr = a; bus_wdata = d; bus_wr = 1; chan_evt = ev;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; chan_evt = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic evt();
    chan_evt = 1; @(posedge clk); @(negedge clk); chan_evt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic exp_pwm;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(ADR, rv); chk("R3 reset reg", rv, 8'h00);
    chk("R3 reset pwm", pwm_out, 0); chk("R3 reset irq", irq, 0);

    wr(ADR, 8'hFF); rd(ADR, rv); chk("R2 layout/reserved", rv, 8'h7C);
    wr(8'h05, 8'h00); rd(ADR, rv); chk("R1 foreign write ignored", rv, 8'h7C);
    rd(8'h05, rv); chk("R1 foreign read zero", rv, 8'h00);

    evt(); chk("R7 irq on flag+ie", irq, 1);
    rd(8'h05, rv);
    wr(ADR, 8'h7C); chk("R5 unarmed write keeps flag", irq, 1);
    rd(ADR, rv); chk("R4 flag set", rv, 8'hFC);
    wr(ADR, 8'h7C); rd(ADR, rv); chk("R5 armed clear", rv, 8'h7C);
    chk("R7 irq drop", irq, 0);

    rd(ADR, rv); evt(); wr(ADR, 8'h7C);
    chk("R5 read with flag 0 does not arm", irq, 1);

    rd(ADR, rv); wr(ADR, 8'hFC); chk("R5 write bit7=1 no clear", irq, 1);
    wr(ADR, 8'h7C); chk("R12 write disarms", irq, 1);

    rd(ADR, rv); evt(); wr(ADR, 8'h7C); chk("R6 event between", irq, 1);
    rd(ADR, rv); wr(ADR, 8'h7C, 1'b1); chk("R6 same-cycle event", irq, 1);
    rd(ADR, rv); wr(ADR, 8'h7C); chk("R5 clear after race", irq, 0);

    wr(ADR, 8'h3C); evt(); chk("R7 ie=0 masks", irq, 0);
    rd(ADR, rv); chk("R7 polled flag", rv, 8'hBC);
    wr(ADR, 8'hFC); chk("R7 enable raises irq", irq, 1);

    exp_pwm = pwm_out;
    for (int e = 0; e < 4; e++) begin
      wr(ADR, 8'h80 | 8'(e << 2));
      center_mode = 1;
      for (int c = 0; c < 16; c++) begin
        cmp_val = CW'(c);
        for (int s = 0; s < 30; s++) begin
          cnt_up  = (s < 15);
          cnt_val = (s < 15) ? CW'(s) : CW'(30 - s);
          @(posedge clk);
          if (e != 0 && cnt_val == cmp_val)
            exp_pwm = cnt_up ? e[0] : ~e[0];
          @(negedge clk);
          if (e == 0) chk("R11 idle hold", pwm_out, exp_pwm);
          else if (e == 2) chk("R9 high-true", pwm_out, exp_pwm);
          else chk("R10 low-true", pwm_out, exp_pwm);
        end
      end
    end

    wr(ADR, 8'h88); center_mode = 1;
    cmp_val = 3; cnt_val = 3; cnt_up = 0;
    @(negedge clk); exp_pwm = 1;
    center_mode = 0;
    for (int s = 0; s < 32; s++) begin
      cnt_up = s[0]; cnt_val = 3;
      @(negedge clk);
      chk("R8 mode off hold", pwm_out, exp_pwm);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule